// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog peripheral that sits on a simple 32-bit register bus and exposes three registers. Software programs a period while the watchdog is stopped. It starts the watchdog by writing an 8-bit enable key into the control register. From then on, software must service the watchdog by writing the status register before the live down-counter in that register runs out. If the counter reaches zero, a sticky roll-over flag is raised. One event output, chosen by a field in the control register, then asserts and stays asserted until software clears the flag. The choices are a reset request, a non-maskable interrupt, a general-purpose interrupt, or nothing.

The counter is sequenced by a three-state machine:
- `ST_OFF`: stopped. It moves to `ST_RUN` on the first clock after the enable key becomes any value other than the stop code.
- `ST_RUN`: counting down. It moves to `ST_HOLD` when the counter expires. It stays in `ST_RUN` on a service write. It moves to `ST_OFF` when the key returns to the stop code.
- `ST_HOLD`: expired, with the counter parked at zero. It moves back to `ST_RUN` on a service write, or to `ST_OFF` when the key returns to the stop code.

While the watchdog runs, the period register is locked. Status writes act as a service strobe, and the data written with them is discarded.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the control register reads 16'h0AD0: enable key (bits [11:4]) = 8'hAD, event select (bits [2:1]) = 2'b00, roll-over flag (bit 15) = 0, all other bits 0. The period register at 0x4 and the status register at 0x8 both read 0, and no event output is high.
- R2: The control register sits at offset 0x0, the period register at 0x4 and the status register at 0x8. A read of the control register with `bus_half` low (a 32-bit access) raises `bus_err` during that access cycle; a 16-bit read of the control register, or any read of the other two registers, leaves `bus_err` low.
- R3: The watchdog is enabled whenever the enable key differs from 8'hAD. The state machine leaves `ST_OFF` on the first clock edge after the key changes. From then on, the status register drops by exactly one on every clock edge spent in `ST_RUN`.
- R4: A write to the period register while the watchdog is disabled loads both the period register and the status register with the written value. While the watchdog is enabled, such a write changes neither register.
- R5: A write to the status register while the watchdog is enabled reloads the status register from the period register and discards the written data; this works from `ST_RUN` and from `ST_HOLD`, and leaves the machine in `ST_RUN`. While the watchdog is disabled, a status write changes nothing.
- R6: In `ST_RUN`, on the edge at which the status register would go from 1 to 0 (or when it is already 0), the status register becomes 0, the roll-over flag is set and the machine enters `ST_HOLD`. The status register stays at 0 in `ST_HOLD`.
- R7: While the roll-over flag is set and the watchdog is enabled, exactly the output chosen by the event select field is high: 2'b00 `evt_reset`, 2'b01 `evt_nmi`, 2'b10 `evt_gpi`, 2'b11 none. At most one event output is ever high.
- R8: Writing 1 to control bit 15 clears the roll-over flag; writing 0 there leaves it unchanged.
- R9: If a control write that clears the flag lands on the same clock edge as an expiry, the flag ends up set.
- R10: While the watchdog is disabled, no event output is high, even with the flag set, and the status register holds its value except for period-register loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 1 = 16-bit access, 0 = 32-bit access |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the access cycle |
| bus_err | output | 1 | Access-size error on a control read |
| evt_reset | output | 1 | Reset request event |
| evt_nmi | output | 1 | Non-maskable interrupt event |
| evt_gpi | output | 1 | General-purpose interrupt event |

## Verification
Two functions can meet on one clock edge: the counter expiring, which sets the roll-over flag, and a control write whose bit 15 asks to clear that flag. The bench provokes this by loading a period of 3 and enabling the watchdog. It then counts edges from the enabling write and issues the clearing write so that it lands on the fourth edge, which is the expiry edge. The outcome is judged by reading the control register back, which must show the flag still set, and by sampling the general-purpose event output, which must be high. The opposite pairing is also covered: a period write arriving one edge after the enabling write must be discarded.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    // control register field layout
    localparam int CTL_W   = 16;
    localparam int EN_W    = 8;
    localparam int EN_LSB  = 4;
    localparam int SEL_W   = 2;
    localparam int SEL_LSB = 1;
    localparam int RO_BIT  = 15;
    localparam int NUM_EVT = 3;

    // register offsets
    localparam int OFF_CTL  = 0;
    localparam int OFF_CNT  = 4;
    localparam int OFF_STAT = 8;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } kwd_state_e;

    typedef enum logic [SEL_W-1:0] {
        EVS_RESET = 2'd0,
        EVS_NMI   = 2'd1,
        EVS_GPI   = 2'd2,
        EVS_NONE  = 2'd3
    } kwd_evsel_e;
endpackage

// File: rtl/kwd_decode.sv
module kwd_decode
    import kwd_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic              bus_half,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CTL_W-1:0]  ctl_view,
    input  logic [DATA_W-1:0] period,
    input  logic [DATA_W-1:0] stat,
    output logic              wr_ctl,
    output logic              wr_cnt,
    output logic              wr_stat,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err
);
    logic hit_ctl, hit_cnt, hit_stat, rd;

    always_comb begin
        hit_ctl  = (bus_addr == ADDR_W'(OFF_CTL));
        hit_cnt  = (bus_addr == ADDR_W'(OFF_CNT));
        hit_stat = (bus_addr == ADDR_W'(OFF_STAT));
        rd       = bus_en && !bus_we;
        wr_ctl   = bus_en && bus_we && hit_ctl;
        wr_cnt   = bus_en && bus_we && hit_cnt;
        wr_stat  = bus_en && bus_we && hit_stat;
        bus_err  = rd && hit_ctl && !bus_half;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            if (hit_ctl)       bus_rdata = DATA_W'(ctl_view);
            else if (hit_cnt)  bus_rdata = period;
            else if (hit_stat) bus_rdata = stat;
        end
    end
endmodule

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
    import kwd_pkg::*;
#(
    parameter logic [EN_W-1:0] DIS_CODE = 8'hAD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [EN_W-1:0]  wr_key,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             wr_ro_clr,
    input  logic             expire,
    output logic [EN_W-1:0]  key,
    output logic [SEL_W-1:0] sel,
    output logic             ro,
    output logic             enabled
);
    kwd_evsel_e sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key   <= DIS_CODE;
            sel_q <= EVS_RESET;
        end else if (wr) begin
            key   <= wr_key;
            sel_q <= kwd_evsel_e'(wr_sel);
        end
    end

    // roll-over flag: expiry wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               ro <= 1'b0;
        else if (expire)          ro <= 1'b1;
        else if (wr && wr_ro_clr) ro <= 1'b0;
    end

    assign sel     = sel_q;
    assign enabled = (key != DIS_CODE);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> ro);
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_ro_clr && !expire) |=> !ro);
    p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!expire && !(wr && wr_ro_clr) && ro) |=> ro);
endmodule

// File: rtl/kwd_timer.sv
module kwd_timer
    import kwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enabled,
    input  logic              wr_cnt,
    input  logic              wr_stat,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] period,
    output logic [DATA_W-1:0] stat,
    output logic              expire
);
    kwd_state_e state, state_nxt;
    logic       svc, load, last;

    assign svc  = wr_stat && enabled;
    assign load = wr_cnt && !enabled;
    assign last = (stat <= DATA_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF: begin
                if (enabled) state_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (!enabled)  state_nxt = ST_OFF;
                else if (svc)  state_nxt = ST_RUN;
                else if (last) state_nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (!enabled) state_nxt = ST_OFF;
                else if (svc) state_nxt = ST_RUN;
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    always_comb begin
        expire = (state == ST_RUN) && enabled && !svc && last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period <= '0;
            stat   <= '0;
        end else if (load) begin
            period <= wdata;
            stat   <= wdata;
        end else if (svc) begin
            stat <= period;
        end else if ((state == ST_RUN) && enabled) begin
            stat <= last ? '0 : stat - DATA_W'(1);
        end
    end

    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && enabled && !svc && !last) |=> (stat == $past(stat) - DATA_W'(1)));
    p_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |=> $stable(period));
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        svc |=> (stat == $past(period)));
    p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> (stat == '0));
    p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && !load) |=> $stable(stat));
endmodule

// File: rtl/kwd_event.sv
module kwd_event
    import kwd_pkg::*;
(
    input  logic               ro,
    input  logic               enabled,
    input  logic [SEL_W-1:0]   sel,
    output logic [NUM_EVT-1:0] evt
);
    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        assign evt[g] = ro && enabled && (sel == SEL_W'(g));
    end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int              ADDR_W   = 4,
    parameter int              DATA_W   = 32,
    parameter logic [EN_W-1:0] DIS_CODE = 8'hAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic              bus_half,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              evt_reset,
    output logic              evt_nmi,
    output logic              evt_gpi
);
    logic               wr_ctl, wr_cnt, wr_stat;
    logic [EN_W-1:0]    key;
    logic [SEL_W-1:0]   sel;
    logic               ro, enabled, expire;
    logic [DATA_W-1:0]  period, stat;
    logic [CTL_W-1:0]   ctl_view;
    logic [NUM_EVT-1:0] evt;

    always_comb begin
        ctl_view                   = '0;
        ctl_view[RO_BIT]           = ro;
        ctl_view[EN_LSB +: EN_W]   = key;
        ctl_view[SEL_LSB +: SEL_W] = sel;
    end

    kwd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_half  (bus_half),
        .bus_addr  (bus_addr),
        .ctl_view  (ctl_view),
        .period    (period),
        .stat      (stat),
        .wr_ctl    (wr_ctl),
        .wr_cnt    (wr_cnt),
        .wr_stat   (wr_stat),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );

    kwd_ctrl #(.DIS_CODE(DIS_CODE)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_ctl),
        .wr_key    (bus_wdata[EN_LSB +: EN_W]),
        .wr_sel    (bus_wdata[SEL_LSB +: SEL_W]),
        .wr_ro_clr (bus_wdata[RO_BIT]),
        .expire    (expire),
        .key       (key),
        .sel       (sel),
        .ro        (ro),
        .enabled   (enabled)
    );

    kwd_timer #(.DATA_W(DATA_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .enabled (enabled),
        .wr_cnt  (wr_cnt),
        .wr_stat (wr_stat),
        .wdata   (bus_wdata),
        .period  (period),
        .stat    (stat),
        .expire  (expire)
    );

    kwd_event u_event (
        .ro      (ro),
        .enabled (enabled),
        .sel     (sel),
        .evt     (evt)
    );

    assign evt_reset = evt[0];
    assign evt_nmi   = evt[1];
    assign evt_gpi   = evt[2];

    p_one_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_reset, evt_nmi, evt_gpi}));
    p_quiet_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |-> !(evt_reset || evt_nmi || evt_gpi));
    p_err_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_en && !bus_we && !bus_half));
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0, bus_half = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err, evt_reset, evt_nmi, evt_gpi;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    logic probe_req = 1'b0;
    logic done = 1'b0;

    logic [31:0] exp_q[$];
    int          kind_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    keyed_watchdog i_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_half(bus_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err),
        .evt_reset(evt_reset), .evt_nmi(evt_nmi), .evt_gpi(evt_gpi)
    );

    // monitor: pops expected items and compares (kind 0 rdata, 1 events {reset,nmi,gpi}, 2 bus_err)
    initial forever begin
        @(negedge clk);
        #2;
        if (probe_req && exp_q.size() > 0) begin
            logic [31:0] e, a;
            int          k;
            string       t;
            e = exp_q.pop_front();
            k = kind_q.pop_front();
            t = tag_q.pop_front();
            if (k == 0)      a = bus_rdata;
            else if (k == 1) a = {29'd0, evt_reset, evt_nmi, evt_gpi};
            else             a = {31'd0, bus_err};
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", t, a, e);
            end
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d, output int t);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_half = (a == 4'h0);
        @(posedge clk);
        #1;
        t = cyc;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic probe(input int kind, input logic [3:0] a, input logic half,
                         input logic [31:0] e, input string tag);
        @(negedge clk);
        if (kind != 1) begin
            bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_half = half;
        end
        exp_q.push_back(e); kind_q.push_back(kind); tag_q.push_back(tag);
        probe_req = 1'b1;
        @(posedge clk);
        #1;
        bus_en = 1'b0; probe_req = 1'b0;
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) begin
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int t, te, tw, ts, te2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        probe(0, 4'h0, 1'b1, 32'h0AD0, "R1 control reset value");
        probe(0, 4'h4, 1'b0, 32'h0,    "R1 period reset value");
        probe(0, 4'h8, 1'b0, 32'h0,    "R1 status reset value");
        probe(1, 4'h0, 1'b0, 32'h0,    "R1 no event after reset");

        probe(2, 4'h0, 1'b0, 32'h1, "R2 32-bit control read errors");
        probe(2, 4'h0, 1'b1, 32'h0, "R2 16-bit control read clean");
        probe(2, 4'h8, 1'b0, 32'h0, "R2 status read clean");

        bus_write(4'h4, 32'd20, t);
        probe(0, 4'h8, 1'b0, 32'd20, "R4 period write preloads status");
        probe(0, 4'h4, 1'b0, 32'd20, "R4 period write while disabled");
        bus_write(4'h8, 32'd5, t);
        probe(0, 4'h8, 1'b0, 32'd20, "R5 status write while disabled ignored");
        repeat (3) @(posedge clk);
        #1;
        probe(0, 4'h8, 1'b0, 32'd20, "R10 counter frozen while disabled");

        // enable, select NMI
        bus_write(4'h0, 32'h05A2, te);
        bus_write(4'h4, 32'd7, t);
        probe(0, 4'h4, 1'b0, 32'd20, "R4 period write while enabled ignored");
        wait_cyc(te + 3);
        probe(0, 4'h8, 1'b0, 32'd18, "R3 first decrements");
        probe(0, 4'h8, 1'b0, 32'd17, "R3 one per clock");

        bus_write(4'h8, 32'h123, tw);
        probe(0, 4'h8, 1'b0, 32'd20, "R5 service reloads from period");
        wait_cyc(tw + 19);
        probe(1, 4'h0, 1'b0, 32'h0,    "R6 no event before expiry");
        probe(1, 4'h0, 1'b0, 32'h2,    "R7 NMI event on expiry");
        probe(0, 4'h8, 1'b0, 32'h0,    "R6 status zero after expiry");
        probe(0, 4'h0, 1'b1, 32'h85A2, "R6 roll-over flag set");
        probe(0, 4'h8, 1'b0, 32'h0,    "R6 status held at zero");

        bus_write(4'h0, 32'h05A0, t);
        probe(1, 4'h0, 1'b0, 32'h4, "R7 reset event selected");
        bus_write(4'h0, 32'h05A4, t);
        probe(1, 4'h0, 1'b0, 32'h1, "R7 GPI event selected");
        bus_write(4'h0, 32'h05A6, t);
        probe(1, 4'h0, 1'b0, 32'h0,    "R7 none selected");
        probe(0, 4'h0, 1'b1, 32'h85A6, "R8 writing zero keeps flag");

        bus_write(4'h0, 32'h85A4, t);
        probe(0, 4'h0, 1'b1, 32'h05A4, "R8 write one clears flag");
        probe(1, 4'h0, 1'b0, 32'h0,    "R8 event drops with flag");

        bus_write(4'h8, 32'h0, ts);
        probe(0, 4'h8, 1'b0, 32'd20, "R5 service from hold");
        wait_cyc(ts + 20);
        probe(1, 4'h0, 1'b0, 32'h1, "R7 GPI after second expiry");

        bus_write(4'h0, 32'h0AD4, t);
        probe(1, 4'h0, 1'b0, 32'h0,    "R10 no event while disabled");
        probe(0, 4'h0, 1'b1, 32'h8AD4, "R10 flag kept while disabled");
        bus_write(4'h8, 32'd9, t);
        probe(0, 4'h8, 1'b0, 32'h0, "R5 status write while disabled");
        bus_write(4'h4, 32'd3, t);
        probe(0, 4'h8, 1'b0, 32'd3, "R4 short period preload");

        // enable with clear, then clear again on the expiry edge
        bus_write(4'h0, 32'h85A4, te2);
        wait_cyc(te2 + 3);
        bus_write(4'h0, 32'h85A4, t);
        probe(0, 4'h0, 1'b1, 32'h85A4, "R9 set wins over clear");
        probe(1, 4'h0, 1'b0, 32'h1,    "R9 GPI event after collision");
        bus_write(4'h0, 32'h85A4, t);
        probe(0, 4'h0, 1'b1, 32'h05A4, "R8 clear after collision");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule